// File: doc/BRIEF.md
# Integer Register-Arithmetic Execute Unit

This block accepts one 32-bit instruction word per clock and carries out the register and immediate arithmetic part of a fixed three-format, three-operand instruction encoding. It works against its own register file of 32-bit entries. A control module splits the word into its fields and turns them into a small set of strobes. A datapath module reads the two sources, computes the result and writes it back on the next rising edge while the valid input is high.

It performs add, subtract and signed set-less-than on two registers, and add-immediate, signed set-less-than-immediate and load-upper-immediate using the 16-bit constant. A side read port returns the current value of any register. Any word outside this subset leaves every register unchanged. Memory access, control flow, multiply and divide, floating point and exception handling are left to other blocks.

Top module: `iexec_top`

## Requirements
- R1: A synchronous reset clears every register to zero, and the test read port then returns zero for all addresses.
- R2: Opcode bits[31:26]=000000 with funct bits[5:0]=100000 writes rs+rt into rd. rs is bits[25:21], rt is bits[20:16] and rd is bits[15:11]. The sum wraps modulo 2^32.
- R3: Opcode 000000 with funct 100010 writes rs-rt into rd, modulo 2^32.
- R4: Opcode 000000 with funct 101010 writes 1 into rd when rs is less than rt as signed numbers, and 0 otherwise.
- R5: Opcode 001000 writes rs plus the sign-extended constant in bits[15:0] into rt.
- R6: Opcode 001010 writes 1 into rt when rs is less than the sign-extended constant as signed numbers, and 0 otherwise.
- R7: Opcode 001111 writes the constant into bits[31:16] of rt and clears bits[15:0].
- R8: Register 0 always reads as zero, both as a source and on the test port, and any write aimed at it is discarded.
- R9: An unknown opcode, an unknown funct under opcode 000000, or valid held low leaves every register unchanged.
- R10: An opcode-000000 word whose shamt field, bits[10:6], is nonzero is treated as unsupported and writes nothing.
- R11: The test port returns the register selected by its address in the same cycle, and a write becomes visible there right after the clock edge that performs it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instrValid | input | 1 | High when instrWord holds an instruction to execute |
| instrWord | input | 32 | Instruction word |
| dbgAddr | input | 5 | Test port register address |
| dbgData | output | DATA_W | Test port register value |

## Verification
The bench builds the block with its defaults: 32-bit data and 32 registers. With these values the 5-bit register fields cover every entry, including register 31 and register 0. Full 32-bit values make the signed comparison across the sign boundary and the wrap of an addition past 0x7FFFFFFF reachable. A reference model in the bench applies each word to its own register copy. The expected register values are then compared through the test port after every instruction, including the words that must have no effect.

// File: rtl/iexec_pkg.sv
`timescale 1ns/1ps
package iexec_pkg;
  localparam int INSTR_W = 32;
  localparam int FIELD_W = 5;
  localparam int IMM_W   = 16;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_ADDI  = 6'b001000;
  localparam logic [5:0] OP_SLTI  = 6'b001010;
  localparam logic [5:0] OP_LUI   = 6'b001111;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_SLT = 2'd2,
    ALU_LUI = 2'd3
  } aluOp_e;

  typedef struct packed {
    logic               wrEn;
    logic [FIELD_W-1:0] wrAddr;
    logic [FIELD_W-1:0] srcAAddr;
    logic [FIELD_W-1:0] srcBAddr;
    logic               useImm;
    aluOp_e             aluOp;
    logic [IMM_W-1:0]   imm;
  } ctrlStrobes_t;
endpackage

// File: rtl/iexec_ctrl.sv
`timescale 1ns/1ps
module iexec_ctrl
  import iexec_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instrWord,
  output ctrlStrobes_t       strobes
);
  logic [5:0]         opField;
  logic [FIELD_W-1:0] rsField;
  logic [FIELD_W-1:0] rtField;
  logic [FIELD_W-1:0] rdField;
  logic [4:0]         shField;
  logic [5:0]         fnField;
  logic               known;

  assign opField = instrWord[31:26];
  assign rsField = instrWord[25:21];
  assign rtField = instrWord[20:16];
  assign rdField = instrWord[15:11];
  assign shField = instrWord[10:6];
  assign fnField = instrWord[5:0];

  always_comb begin
    known            = 1'b0;
    strobes.wrAddr   = rtField;
    strobes.srcAAddr = rsField;
    strobes.srcBAddr = rtField;
    strobes.useImm   = 1'b1;
    strobes.aluOp    = ALU_ADD;
    strobes.imm      = instrWord[IMM_W-1:0];
    unique case (opField)
      OP_RTYPE: begin
        strobes.wrAddr = rdField;
        strobes.useImm = 1'b0;
        if (shField == 5'd0) begin
          unique case (fnField)
            FN_ADD:  begin known = 1'b1; strobes.aluOp = ALU_ADD; end
            FN_SUB:  begin known = 1'b1; strobes.aluOp = ALU_SUB; end
            FN_SLT:  begin known = 1'b1; strobes.aluOp = ALU_SLT; end
            default: known = 1'b0;
          endcase
        end
      end
      OP_ADDI: begin known = 1'b1; strobes.aluOp = ALU_ADD; end
      OP_SLTI: begin known = 1'b1; strobes.aluOp = ALU_SLT; end
      OP_LUI:  begin known = 1'b1; strobes.aluOp = ALU_LUI; end
      default: known = 1'b0;
    endcase
    strobes.wrEn = instrValid & known;
  end

  // R9: words outside the subset never raise the write strobe
  a_r9_unknown_no_write: assert property (@(posedge clk) disable iff (rst)
    (opField != OP_RTYPE && opField != OP_ADDI && opField != OP_SLTI && opField != OP_LUI)
      |-> !strobes.wrEn);

  // R10: register-format word with nonzero shamt is rejected
  a_r10_shamt_reject: assert property (@(posedge clk) disable iff (rst)
    (opField == OP_RTYPE && shField != 5'd0) |-> !strobes.wrEn);

  // R5: immediate-format results always land in the rt field
  a_r5_imm_dest: assert property (@(posedge clk) disable iff (rst)
    (strobes.wrEn && opField != OP_RTYPE) |-> (strobes.wrAddr == instrWord[20:16]));

  // R9: valid low means no write
  a_r9_valid_gate: assert property (@(posedge clk) disable iff (rst)
    !instrValid |-> !strobes.wrEn);
endmodule

// File: rtl/iexec_dpath.sv
`timescale 1ns/1ps
module iexec_dpath
  import iexec_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int REG_CNT = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrlStrobes_t       strobes,
  input  logic [FIELD_W-1:0] dbgAddr,
  output logic [DATA_W-1:0]  dbgData
);
  localparam int LUI_PAD = DATA_W - IMM_W;

  logic [DATA_W-1:0] regFile [REG_CNT];
  logic [DATA_W-1:0] srcA;
  logic [DATA_W-1:0] srcB;
  logic [DATA_W-1:0] immExt;
  logic [DATA_W-1:0] wrData;

  function automatic logic [DATA_W-1:0] readReg(input logic [FIELD_W-1:0] addr,
                                                input logic [DATA_W-1:0] arr [REG_CNT]);
    if (addr == '0 || int'(addr) >= REG_CNT) return '0;
    return arr[addr];
  endfunction

  assign srcA    = readReg(strobes.srcAAddr, regFile);
  assign immExt  = {{LUI_PAD{strobes.imm[IMM_W-1]}}, strobes.imm};
  assign srcB    = strobes.useImm ? immExt : readReg(strobes.srcBAddr, regFile);
  assign dbgData = readReg(dbgAddr, regFile);

  always_comb begin
    unique case (strobes.aluOp)
      ALU_ADD: wrData = srcA + srcB;
      ALU_SUB: wrData = srcA - srcB;
      ALU_SLT: wrData = {{(DATA_W-1){1'b0}}, ($signed(srcA) < $signed(srcB))};
      ALU_LUI: wrData = {strobes.imm, {LUI_PAD{1'b0}}};
      default: wrData = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REG_CNT; i++) regFile[i] <= '0;
    end else begin
      for (int i = 1; i < REG_CNT; i++) begin
        if (strobes.wrEn && int'(strobes.wrAddr) == i) regFile[i] <= wrData;
      end
    end
  end

  // R1: after a reset cycle every read is zero
  a_r1_reset_clear: assert property (@(posedge clk) rst |=> (dbgData == '0));

  // R8: register 0 reads as zero
  a_r8_zero_reg: assert property (@(posedge clk) disable iff (rst)
    (dbgAddr == '0) |-> (dbgData == '0));

  // R4 and R6: compare results are 0 or 1
  a_r4_slt_bool: assert property (@(posedge clk) disable iff (rst)
    (strobes.wrEn && strobes.aluOp == ALU_SLT) |-> (wrData[DATA_W-1:1] == '0));

  // R7: upper-immediate clears the low half
  a_r7_lui_low_zero: assert property (@(posedge clk) disable iff (rst)
    (strobes.wrEn && strobes.aluOp == ALU_LUI) |-> (wrData[IMM_W-1:0] == '0));

  // R9: with no write strobe, the register under the test port keeps its value
  a_r9_hold_state: assert property (@(posedge clk) disable iff (rst)
    !strobes.wrEn |=> (readReg($past(dbgAddr), regFile) == $past(dbgData)));
endmodule

// File: rtl/iexec_top.sv
`timescale 1ns/1ps
module iexec_top
  import iexec_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int REG_CNT = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [FIELD_W-1:0] dbgAddr,
  output logic [DATA_W-1:0]  dbgData
);
  ctrlStrobes_t strobes;

  iexec_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .instrValid (instrValid),
    .instrWord  (instrWord),
    .strobes    (strobes)
  );

  iexec_dpath #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) u_dpath (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .dbgAddr (dbgAddr),
    .dbgData (dbgData)
  );
endmodule

// File: tb/iexec_top_bench.sv
`timescale 1ns/1ps
module iexec_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instrValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic [4:0]  dbgAddr = '0;
  logic [31:0] dbgData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int          addr;
    logic [31:0] exp;
    string       req;
  } expItem_t;

  expItem_t    expQ[$];
  logic [31:0] model [32];

  iexec_top u_iexec_top (
    .clk(clk), .rst(rst), .instrValid(instrValid), .instrWord(instrWord),
    .dbgAddr(dbgAddr), .dbgData(dbgData)
  );

  always #2 clk = ~clk;

  function automatic logic [31:0] rWord(input logic [5:0] fn, input int rs, input int rt,
                                        input int rd, input int sh);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
  endfunction

  function automatic logic [31:0] iWord(input logic [5:0] op, input int rs, input int rt,
                                        input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic void modelExec(input logic [31:0] w);
    logic [5:0]  op;
    logic [31:0] a, b, ie;
    int          rs, rt, rd;
    op = w[31:26];
    rs = int'(w[25:21]); rt = int'(w[20:16]); rd = int'(w[15:11]);
    a  = model[rs]; b = model[rt];
    ie = {{16{w[15]}}, w[15:0]};
    if (op == 6'b000000 && w[10:6] == 5'd0) begin
      if (w[5:0] == 6'b100000) model[rd] = a + b;
      else if (w[5:0] == 6'b100010) model[rd] = a - b;
      else if (w[5:0] == 6'b101010) model[rd] = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    end else if (op == 6'b001000) model[rt] = a + ie;
    else if (op == 6'b001010) model[rt] = ($signed(a) < $signed(ie)) ? 32'd1 : 32'd0;
    else if (op == 6'b001111) model[rt] = {w[15:0], 16'h0000};
    model[0] = '0;
  endfunction

  task automatic issue(input logic [31:0] w, input bit v = 1'b1);
    @(negedge clk);
    instrValid = v;
    instrWord  = w;
    @(negedge clk);
    instrValid = 1'b0;
    if (v) modelExec(w);
  endtask

  task automatic expectReg(input int addr, input string req);
    expItem_t it;
    it.addr = addr; it.exp = model[addr]; it.req = req;
    expQ.push_back(it);
  endtask

  task automatic drain();
    wait (expQ.size() == 0);
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 32; i++) model[i] = '0;
  endtask

  // monitor: pops one expected item per cycle and compares at the test port
  always @(posedge clk) begin
    expItem_t it;
    #1;
    if (expQ.size() != 0) begin
      it = expQ.pop_front();
      dbgAddr = 5'(it.addr);
      #1;
      checks++;
      if (dbgData !== it.exp) begin
        errors++;
        $display("FAIL %s reg%0d actual=%h expected=%h", it.req, it.addr, dbgData, it.exp);
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    expectReg(0, "R1"); expectReg(1, "R1"); expectReg(17, "R1"); expectReg(31, "R1");
    drain();

    // R5 add-immediate, positive and negative constants
    issue(iWord(6'b001000, 0, 1, 16'd5));      expectReg(1, "R5");
    issue(iWord(6'b001000, 0, 2, 16'hFFFD));   expectReg(2, "R5");
    issue(iWord(6'b001000, 1, 31, 16'h0100));  expectReg(31, "R5");
    drain();

    // R2 add, R3 subtract
    issue(rWord(6'b100000, 1, 2, 3, 0));       expectReg(3, "R2");
    issue(rWord(6'b100010, 2, 1, 4, 0));       expectReg(4, "R3");
    issue(rWord(6'b100010, 1, 2, 13, 0));      expectReg(13, "R3");
    drain();

    // R4 signed register compare, both outcomes
    issue(rWord(6'b101010, 2, 1, 5, 0));       expectReg(5, "R4");
    issue(rWord(6'b101010, 1, 2, 6, 0));       expectReg(6, "R4");
    issue(rWord(6'b101010, 1, 1, 14, 0));      expectReg(14, "R4");
    drain();

    // R6 signed immediate compare
    issue(iWord(6'b001010, 2, 7, 16'hFFFE));   expectReg(7, "R6");
    issue(iWord(6'b001010, 1, 8, 16'd5));      expectReg(8, "R6");
    drain();

    // R7 upper immediate
    issue(iWord(6'b001111, 0, 9, 16'h1234));   expectReg(9, "R7");
    issue(iWord(6'b001000, 9, 9, 16'h0042));   expectReg(9, "R7");
    drain();

    // R2 wrap past the signed maximum
    issue(iWord(6'b001111, 0, 10, 16'h7FFF));
    issue(iWord(6'b001000, 10, 10, 16'h7FFF));
    issue(iWord(6'b001000, 10, 10, 16'h7FFF));
    issue(iWord(6'b001000, 10, 10, 16'h0002));
    issue(rWord(6'b100000, 10, 10, 11, 0));    expectReg(10, "R2"); expectReg(11, "R2");
    drain();

    // R8 writes to register 0 discarded, register 0 reads zero as a source
    issue(iWord(6'b001000, 0, 0, 16'd7));      expectReg(0, "R8");
    issue(rWord(6'b100000, 0, 1, 12, 0));      expectReg(12, "R8");
    drain();

    // R9 unknown opcode, unknown funct, valid low
    issue(iWord(6'b111111, 0, 1, 16'd99));     expectReg(1, "R9");
    issue(rWord(6'b100100, 2, 2, 1, 0));       expectReg(1, "R9");
    issue(iWord(6'b100011, 2, 3, 16'd4));      expectReg(3, "R9");
    issue(iWord(6'b001000, 0, 1, 16'd77), 1'b0); expectReg(1, "R9");
    drain();

    // R10 nonzero shamt under register format
    issue(rWord(6'b100000, 2, 2, 1, 3));       expectReg(1, "R10");
    drain();

    // R11 back-to-back writes visible right after each edge, high register index
    issue(iWord(6'b001000, 31, 30, 16'd1));
    issue(rWord(6'b100000, 30, 30, 29, 0));    expectReg(30, "R11"); expectReg(29, "R11");
    drain();

    // R1 reset in mid-run clears written registers
    doReset();
    expectReg(3, "R1"); expectReg(9, "R1"); expectReg(31, "R1");
    drain();

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule